// File: doc/BRIEF.md
# Linked Context Breakpoint Checker

This block decides whether a watchpoint that is linked to a breakpoint slot may fire. A watchpoint can name another slot through a link number. That named slot must pass its context check before the watchpoint produces an event. The checker reads three things: the debug ID word, which gives the implemented slot counts, the per-slot control and value registers, and the processor's current exception level and context identifier. It returns one match bit.

A link passes only when all four of these hold. The target slot is implemented and context-aware. The slot is enabled. Its type field selects "linked context ID match". The current context identifier equals the slot's stored value. Every other combination yields no match without any error indication, and that includes reserved type codes and out-of-range links. The decision is made combinationally. It is then registered once, so that it sits cleanly in a pipelined debug path.

Top module: `link_ctx_checker`

## Requirements
- R1: Both slot counts in the debug ID word are stored as the count minus one. The breakpoint count is in bits 27:24 and the context-aware comparator count is in bits 23:20. Context-aware slots are the highest-numbered implemented slots. A link whose number lies between the two bounds inclusive can match.
- R2: A link number greater than the breakpoint field (bits 27:24) gives no match.
- R3: A link number less than the breakpoint field minus the context comparator field gives no match.
- R4: When bit 0 of the selected slot's control word is 0 (slot disabled), the result is no match.
- R5: The type is read from control bits 23:20. Only the value 3 can produce a match. Every other value gives no match, including 5, 9, 11 and 0.
- R6: When the current exception level (2-bit input) is 2 or 3, the result is no match.
- R7: For an eligible link, the result is a match exactly when all 32 context-identifier bits equal value-register bits 31:0. Value bits 63:32 have no effect.
- R8: The match output appears one clock after its inputs are sampled. A synchronous active-high reset clears it to 0.
- R9: The watchpoint count field of the debug ID word (bits 31:28) has no effect on the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dbg_id | input | 32 | Debug ID word holding the slot counts |
| link_num | input | 4 | Slot number named by the watchpoint |
| slot_ctl_flat | input | 512 | 16 control words of 32 bits each; slot i is at bits i*32+31:i*32 |
| slot_val_flat | input | 1024 | 16 value words of 64 bits each; slot i is at bits i*64+63:i*64 |
| cur_el | input | 2 | Current exception level |
| ctx_id | input | 32 | Current context identifier |
| match_q | output | 1 | Registered link-pass result |

## Verification
The hard case is a positive match. It needs five independent conditions to line up at once: a link inside the context-aware window, the enable bit set, type code 3, exception level 0 or 1, and an exact 32-bit identifier match. Uniform random stimulus would almost never produce it. The stimulus therefore picks the link inside the window most of the time, sets type 3 and the enable bit with high probability, and copies the context identifier into the slot's value so that the comparison succeeds. It then perturbs one of these choices at a time. Directed cases pin the window edges, the reserved type codes and the ignored upper value bits.

// File: rtl/lcbc_pkg.sv
`timescale 1ns/1ps
package lcbc_pkg;
  localparam int ID_W      = 32;
  localparam int CNT_W     = 4;
  localparam int BRP_LSB   = 24;
  localparam int CTXC_LSB  = 20;
  localparam int EL_W      = 2;
  localparam int CID_W     = 32;
  localparam int EN_BIT    = 0;
  localparam int TYPE_LSB  = 20;
  localparam int TYPE_W    = 4;
  localparam int EL_MAXCTX = 1;

  typedef enum logic [TYPE_W-1:0] {
    BT_CTX_LINKED  = 4'd3,
    BT_ADDR_MISM   = 4'd5,
    BT_VMID_LINKED = 4'd9,
    BT_CTXVMID_LNK = 4'd11
  } bp_type_e;
endpackage

// File: rtl/lcbc_slot_mux.sv
`timescale 1ns/1ps
module lcbc_slot_mux #(
  parameter int NSLOT  = 16,
  parameter int CTL_W  = 32,
  parameter int VAL_W  = 64,
  parameter int LINK_W = $clog2(NSLOT)
) (
  input  logic [LINK_W-1:0]      sel,
  input  logic [NSLOT*CTL_W-1:0] ctl_flat,
  input  logic [NSLOT*VAL_W-1:0] val_flat,
  output logic [CTL_W-1:0]       ctl_o,
  output logic [VAL_W-1:0]       val_o
);
  logic [CTL_W-1:0] ctl_arr [NSLOT];
  logic [VAL_W-1:0] val_arr [NSLOT];

  for (genvar g = 0; g < NSLOT; g++) begin : g_unpack
    assign ctl_arr[g] = ctl_flat[g*CTL_W +: CTL_W];
    assign val_arr[g] = val_flat[g*VAL_W +: VAL_W];
  end

  always_comb begin
    ctl_o = '0;
    val_o = '0;
    if (int'(sel) < NSLOT) begin
      ctl_o = ctl_arr[sel];
      val_o = val_arr[sel];
    end
  end
endmodule

// File: rtl/lcbc_range.sv
`timescale 1ns/1ps
module lcbc_range #(
  parameter int LINK_W = 4,
  parameter int CNT_W  = 4
) (
  input  logic [LINK_W-1:0] link,
  input  logic [CNT_W-1:0]  brp_m1,
  input  logic [CNT_W-1:0]  ctx_m1,
  output logic              in_window
);
  int top_i, low_i, lnk_i;

  always_comb begin
    lnk_i = int'(link);
    top_i = int'(brp_m1);
    low_i = int'(brp_m1) - int'(ctx_m1);
    in_window = (lnk_i <= top_i) && (lnk_i >= low_i);
  end
endmodule

// File: rtl/lcbc_ctx_eval.sv
`timescale 1ns/1ps
module lcbc_ctx_eval
  import lcbc_pkg::*;
#(
  parameter int CTL_W = 32,
  parameter int VAL_W = 64
) (
  input  logic [CTL_W-1:0] ctl,
  input  logic [VAL_W-1:0] val,
  input  logic [EL_W-1:0]  el,
  input  logic [CID_W-1:0] cid,
  output logic             pass
);
  logic             en;
  logic [TYPE_W-1:0] bt;
  logic             el_ok;
  logic             id_eq;

  always_comb begin
    en    = ctl[EN_BIT];
    bt    = ctl[TYPE_LSB +: TYPE_W];
    el_ok = int'(el) <= EL_MAXCTX;
    id_eq = (val[CID_W-1:0] == cid);
    pass  = 1'b0;
    if (en) begin
      case (bt)
        BT_CTX_LINKED: pass = el_ok && id_eq;
        default:       pass = 1'b0;
      endcase
    end
  end
endmodule

// File: rtl/link_ctx_checker.sv
`timescale 1ns/1ps
module link_ctx_checker
  import lcbc_pkg::*;
#(
  parameter int NSLOT  = 16,
  parameter int CTL_W  = 32,
  parameter int VAL_W  = 64,
  parameter int LINK_W = $clog2(NSLOT)
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [ID_W-1:0]        dbg_id,
  input  logic [LINK_W-1:0]      link_num,
  input  logic [NSLOT*CTL_W-1:0] slot_ctl_flat,
  input  logic [NSLOT*VAL_W-1:0] slot_val_flat,
  input  logic [EL_W-1:0]        cur_el,
  input  logic [CID_W-1:0]       ctx_id,
  output logic                   match_q
);
  logic [CNT_W-1:0] brp_m1, ctx_m1;
  logic [CTL_W-1:0] sel_ctl;
  logic [VAL_W-1:0] sel_val;
  logic             in_window, ctx_pass, hit_c;

  assign brp_m1 = dbg_id[BRP_LSB  +: CNT_W];
  assign ctx_m1 = dbg_id[CTXC_LSB +: CNT_W];

  lcbc_slot_mux #(.NSLOT(NSLOT), .CTL_W(CTL_W), .VAL_W(VAL_W), .LINK_W(LINK_W)) u_mux (
    .sel(link_num), .ctl_flat(slot_ctl_flat), .val_flat(slot_val_flat),
    .ctl_o(sel_ctl), .val_o(sel_val)
  );

  lcbc_range #(.LINK_W(LINK_W), .CNT_W(CNT_W)) u_range (
    .link(link_num), .brp_m1(brp_m1), .ctx_m1(ctx_m1), .in_window(in_window)
  );

  lcbc_ctx_eval #(.CTL_W(CTL_W), .VAL_W(VAL_W)) u_eval (
    .ctl(sel_ctl), .val(sel_val), .el(cur_el), .cid(ctx_id), .pass(ctx_pass)
  );

  assign hit_c = in_window & ctx_pass;

  always_ff @(posedge clk) begin
    if (rst) match_q <= 1'b0;
    else     match_q <= hit_c;
  end

  // R8: reset clears the output on the next edge
  a_r8_reset_clears: assert property (@(posedge clk) rst |=> !match_q);
  // R2: link above the breakpoint field never matches
  a_r2_above_top: assert property (@(posedge clk) disable iff (rst)
    (int'(link_num) > int'(dbg_id[27:24])) |=> !match_q);
  // R3: link below the context-aware window never matches
  a_r3_below_low: assert property (@(posedge clk) disable iff (rst)
    (int'(link_num) < int'(dbg_id[27:24]) - int'(dbg_id[23:20])) |=> !match_q);
  // R4: disabled slot never matches
  a_r4_disabled: assert property (@(posedge clk) disable iff (rst)
    !sel_ctl[0] |=> !match_q);
  // R5: non-context type never matches
  a_r5_type_gate: assert property (@(posedge clk) disable iff (rst)
    (sel_ctl[23:20] != 4'd3) |=> !match_q);
  // R6: exception level above 1 never matches
  a_r6_high_el: assert property (@(posedge clk) disable iff (rst)
    (cur_el > 2'd1) |=> !match_q);
  // R7: identifier mismatch never matches
  a_r7_id_mismatch: assert property (@(posedge clk) disable iff (rst)
    (sel_val[31:0] != ctx_id) |=> !match_q);
endmodule

// File: tb/link_ctx_checker_test.sv
`timescale 1ns/1ps
module link_ctx_checker_test;
  localparam int NSLOT = 16;

  logic clk = 1'b0;
  logic rst;
  logic [31:0] dbg_id;
  logic [3:0]  link_num;
  logic [NSLOT*32-1:0] slot_ctl_flat;
  logic [NSLOT*64-1:0] slot_val_flat;
  logic [1:0]  cur_el;
  logic [31:0] ctx_id;
  logic        match_q;

  logic [31:0] ctl [NSLOT];
  logic [63:0] val [NSLOT];

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  link_ctx_checker uut (
    .clk(clk), .rst(rst), .dbg_id(dbg_id), .link_num(link_num),
    .slot_ctl_flat(slot_ctl_flat), .slot_val_flat(slot_val_flat),
    .cur_el(cur_el), .ctx_id(ctx_id), .match_q(match_q)
  );

  always_comb begin
    for (int i = 0; i < NSLOT; i++) begin
      slot_ctl_flat[i*32 +: 32] = ctl[i];
      slot_val_flat[i*64 +: 64] = val[i];
    end
  end

  function automatic bit model(output string tag);
    int brp = int'(dbg_id[27:24]);
    int cc  = int'(dbg_id[23:20]);
    int l   = int'(link_num);
    logic [31:0] c = ctl[l];
    logic [63:0] v = val[l];
    if (l > brp)          begin tag = "R2"; return 0; end
    if (l < brp - cc)     begin tag = "R3"; return 0; end
    if (!c[0])            begin tag = "R4"; return 0; end
    if (c[23:20] != 4'd3) begin tag = "R5"; return 0; end
    if (cur_el > 2'd1)    begin tag = "R6"; return 0; end
    tag = "R7";
    return v[31:0] == ctx_id;
  endfunction

  task automatic run(input string t);
    string mt;
    bit exp;
    exp = model(mt);
    if (rst) begin exp = 0; mt = "R8"; end
    if (t != "") mt = t;
    @(posedge clk);
    @(negedge clk);
    checks++;
    if (match_q !== exp) begin
      errors++;
      $display("FAIL %s: match_q=%b expected=%b", mt, match_q, exp);
    end
  endtask

  task automatic setup_pass(input int l);
    dbg_id = {4'h3, 4'd5, 4'd2, 20'h0};
    for (int i = 0; i < NSLOT; i++) begin ctl[i] = '0; val[i] = '0; end
    ctx_id = 32'hA5C3_1E07;
    ctl[l] = 32'h0030_0001;
    val[l] = {32'h0, ctx_id};
    link_num = 4'(l);
    cur_el = 2'd1;
  endtask

  initial begin
    #(200000 * 10);
    errors++;
    $display("FAIL watchdog: run did not end, expected completion");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst = 1'b1;
    setup_pass(4);
    @(negedge clk);
    run("R8");
    run("R8");
    rst = 1'b0;
    run("R7");
    // window 3..5 (brp=5, ctx=2)
    setup_pass(5); run("R1");
    setup_pass(3); run("R1");
    setup_pass(6); dbg_id = {4'h3, 4'd5, 4'd2, 20'h0}; run("R2");
    setup_pass(2); run("R3");
    setup_pass(4); ctl[4][0] = 1'b0; run("R4");
    setup_pass(4); ctl[4][23:20] = 4'd5;  run("R5");
    setup_pass(4); ctl[4][23:20] = 4'd9;  run("R5");
    setup_pass(4); ctl[4][23:20] = 4'd11; run("R5");
    setup_pass(4); ctl[4][23:20] = 4'd0;  run("R5");
    setup_pass(4); cur_el = 2'd2; run("R6");
    setup_pass(4); cur_el = 2'd3; run("R6");
    setup_pass(4); cur_el = 2'd0; run("R6");
    setup_pass(4); ctx_id[31] = ~ctx_id[31]; run("R7");
    setup_pass(4); ctx_id[0] = ~ctx_id[0]; run("R7");
    setup_pass(4); val[4][63:32] = 32'hFFFF_FFFF; run("R7");
    setup_pass(4); dbg_id[31:28] = 4'h0; run("R9");
    setup_pass(4); dbg_id[31:28] = 4'hF; run("R9");
    setup_pass(6); dbg_id[31:28] = 4'hF; run("R9");
    // reset mid-run with passing inputs
    setup_pass(4); rst = 1'b1; run("R8"); rst = 1'b0; run("R7");

    for (int n = 0; n < 3000; n++) begin
      int brp, cc, l;
      brp = $urandom_range(0, 15);
      cc  = $urandom_range(0, brp);
      dbg_id = {4'($urandom_range(0, 15)), 4'(brp), 4'(cc), 20'($urandom)};
      ctx_id = $urandom;
      for (int i = 0; i < NSLOT; i++) begin
        ctl[i] = $urandom;
        ctl[i][0] = ($urandom_range(0, 3) != 0);
        if ($urandom_range(0, 1) == 1) ctl[i][23:20] = 4'd3;
        val[i] = {32'($urandom), 32'($urandom)};
        if ($urandom_range(0, 2) != 0) val[i][31:0] = ctx_id;
      end
      if ($urandom_range(0, 3) != 0) l = $urandom_range(brp - cc, brp);
      else l = $urandom_range(0, 15);
      link_num = 4'(l);
      cur_el = ($urandom_range(0, 3) != 0) ? 2'($urandom_range(0, 1)) : 2'($urandom_range(2, 3));
      run("");
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule